// File: doc/BRIEF.md
# Little-Endian Byte/Word Data Memory Port

This block is a synchronous data memory reached through a 16-bit byte address and a 16-bit data path. A single strobe pair (read, write) and a size select let a client move either one byte or one 16-bit word per clock. Words are stored with the less significant byte at the even address and the more significant byte at the next odd address. Bytes may sit at any address; words must sit at even addresses, and a word access at an odd address is refused and reported.

The array holds `MEM_BYTES` bytes and is addressed modulo its size, so any depth up to the full 64 KB logical space can be built. Addresses below `IO_LIMIT` belong to memory-mapped peripheral registers: such an access raises an I/O select output and leaves the array alone. The top 32 bytes of the space hold the interrupt vector table, and an address in that range raises a vector-region flag.

Top module: `le_mem_port`

## Requirements
- R1: The byte address is 16 bits; an array access uses the address modulo `MEM_BYTES`, so addresses that differ by `MEM_BYTES` reach the same byte.
- R2: A word access at an even address A stores `wdata_i[7:0]` at A and `wdata_i[15:8]` at A+1; a word read returns byte A in bits 7:0 and byte A+1 in bits 15:8.
- R3: A byte write (`byte_i`=1) at an even or odd address stores `wdata_i[7:0]` at that address only; the other byte of the same word keeps its value.
- R4: A byte read returns the addressed byte in bits 7:0 with bits 15:8 zero.
- R5: `rdata_o` is registered: it takes the read result one clock after the read strobe and holds its value in cycles without a read; after reset it is zero.
- R6: A word access (`byte_i`=0) at an odd address writes nothing, a read of it returns zero, and `align_err_o` is high for exactly the following clock cycle.
- R7: `vec_hit_o` is high, without delay, exactly when `addr_i` lies in 0xFFE0 to 0xFFFF.
- R8: While a strobe is active and `addr_i` is below `IO_LIMIT`, `io_sel_o` is high in the same cycle; the array is not written and a read returns zero.
- R9: With read and write strobes in the same cycle, the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 16 | Write data |
| byte_i | input | 1 | 1: byte access, 0: word access |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Registered read data |
| align_err_o | output | 1 | Odd-address word access seen last cycle |
| vec_hit_o | output | 1 | Address lies in the vector table region |
| io_sel_o | output | 1 | Strobed access falls in the peripheral window |

## Verification
The bench fills the whole array, then aims at the lane boundaries: a byte write to an odd address that a design with swapped lanes would land in the low byte, and word reads that would come back byte-reversed under a big-endian layout. Odd-address word writes are followed by even-address reads of both neighbouring bytes, so a design that still wrote a lane or failed to pulse the error flag shows it. The vector flag is probed at 0xFFDF, 0xFFE0 and 0xFFFF to catch an off-by-one range, and the peripheral window is written then re-read through an aliasing address to expose a write that leaked into the array. Combined read-write cycles and idle cycles catch a read that sees fresh data or an output that fails to hold.

// File: rtl/le_mem_pkg.sv
package le_mem_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned ADDR_W = 16;

  typedef logic [BYTE_W-1:0]             byte_t;
  typedef logic [WORD_W-1:0]             word_t;
  typedef logic [LANES-1:0]              lane_en_t;
  typedef logic [LANES-1:0][BYTE_W-1:0]  lane_bytes_t;
endpackage

// File: rtl/le_mem_decode.sv
module le_mem_decode
  import le_mem_pkg::*;
#(
  parameter logic [ADDR_W-1:0] IO_LIMIT = 16'h0200,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFE0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              misalign_o,
  output logic              io_o,
  output logic              vec_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);
  logic acc, ok;

  assign acc        = rd_i | wr_i;
  assign misalign_o = acc & ~byte_i & addr_i[0];
  assign io_o       = acc & (addr_i < IO_LIMIT);
  assign vec_o      = (addr_i >= VEC_BASE);
  assign ok         = acc & ~misalign_o & ~io_o;
  assign rd_ok_o    = rd_i & ok;
  assign wr_ok_o    = wr_i & ok;
endmodule

// File: rtl/le_mem_lanes.sv
module le_mem_lanes
  import le_mem_pkg::*;
(
  input  logic        addr0_i,
  input  logic        byte_i,
  input  logic        wr_ok_i,
  input  word_t       wdata_i,
  input  lane_bytes_t rbytes_i,
  output lane_en_t    we_o,
  output lane_bytes_t wbytes_o,
  output word_t       rfmt_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // byte writes: lane chosen by addr bit 0, data always from the low byte
    assign we_o[g]     = wr_ok_i & (~byte_i | (addr0_i == g[0]));
    assign wbytes_o[g] = byte_i ? wdata_i[BYTE_W-1:0] : wdata_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (byte_i) begin
      rfmt_o = '0;
      rfmt_o[BYTE_W-1:0] = rbytes_i[addr0_i];
    end else begin
      rfmt_o = rbytes_i;
    end
  end
endmodule

// File: rtl/le_mem_array.sv
module le_mem_array
  import le_mem_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic [IDX_W-1:0] idx_i,
  input  lane_en_t         we_i,
  input  lane_bytes_t      wbytes_i,
  output lane_bytes_t      rbytes_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    byte_t bank [WORDS];

    always_ff @(posedge clk_i) begin
      if (we_i[g]) bank[idx_i] <= wbytes_i[g];
    end

    assign rbytes_o[g] = bank[idx_i];
  end
endmodule

// File: rtl/le_mem_port.sv
module le_mem_port
  import le_mem_pkg::*;
#(
  parameter int unsigned       MEM_BYTES = 2048,
  parameter logic [15:0]       IO_LIMIT  = 16'h0200,
  localparam int unsigned      WORDS     = MEM_BYTES / LANES,
  localparam int unsigned      IDX_W     = $clog2(WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  input  logic        byte_i,
  input  logic        rd_i,
  input  logic        wr_i,
  output logic [15:0] rdata_o,
  output logic        align_err_o,
  output logic        vec_hit_o,
  output logic        io_sel_o
);
  logic        misalign, rd_ok, wr_ok;
  lane_en_t    lane_we;
  lane_bytes_t wbytes, rbytes;
  word_t       rfmt;
  word_t       rdata_q;
  logic        err_q;

  le_mem_decode #(.IO_LIMIT(IO_LIMIT), .VEC_BASE(16'hFFE0)) i_decode (
    .addr_i    (addr_i),
    .byte_i    (byte_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .misalign_o(misalign),
    .io_o      (io_sel_o),
    .vec_o     (vec_hit_o),
    .rd_ok_o   (rd_ok),
    .wr_ok_o   (wr_ok)
  );

  le_mem_lanes i_lanes (
    .addr0_i (addr_i[0]),
    .byte_i  (byte_i),
    .wr_ok_i (wr_ok),
    .wdata_i (wdata_i),
    .rbytes_i(rbytes),
    .we_o    (lane_we),
    .wbytes_o(wbytes),
    .rfmt_o  (rfmt)
  );

  le_mem_array #(.WORDS(WORDS)) i_array (
    .clk_i   (clk_i),
    .idx_i   (addr_i[IDX_W:1]),
    .we_i    (lane_we),
    .wbytes_i(wbytes),
    .rbytes_o(rbytes)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= misalign;
      if (rd_i) rdata_q <= rd_ok ? rfmt : '0;
    end
  end

  assign rdata_o     = rdata_q;
  assign align_err_o = err_q;

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> $past((rd_i | wr_i) & ~byte_i & addr_i[0])); // R6
  AST_ODD_WORD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~byte_i & addr_i[0]) |-> (lane_we == '0)); // R6
  AST_IO_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_o |-> (lane_we == '0)); // R8
  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> $onehot0(lane_we)); // R3
  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i & byte_i) |=> (rdata_o[15:8] == 8'h00)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R5
  AST_VEC_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_hit_o |-> (&addr_i[15:5])); // R7
endmodule

// File: tb/test_le_mem_port.sv
module test_le_mem_port;
  localparam int unsigned MEM_BYTES = 2048;
  localparam int unsigned IO_LIMIT  = 'h200;
  localparam time         CLK_PER   = 10ns;
  localparam int unsigned WATCHDOG  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        bsel = 1'b0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] rdata;
  logic        aerr, vhit, iosel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  model [MEM_BYTES];
  logic [15:0] exp_rdata = '0;

  always #(CLK_PER/2) clk = ~clk;

  le_mem_port #(.MEM_BYTES(MEM_BYTES), .IO_LIMIT(16'(IO_LIMIT))) i_le_mem_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .byte_i(bsel),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .align_err_o(aerr),
    .vec_hit_o(vhit), .io_sel_o(iosel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after checking registered outputs.
  task automatic op(input logic [15:0] a, input logic [15:0] d, input bit b,
                    input bit r, input bit w, input string req);
    bit acc, mis, io, ok;
    int i;
    logic exp_err;
    addr = a; wdata = d; bsel = b; rd = r; wr = w;
    acc = r | w;
    mis = acc && !b && a[0];
    io  = acc && (a < IO_LIMIT);
    ok  = acc && !mis && !io;
    i   = int'(a) % MEM_BYTES;
    #1;
    chk(vhit == (a >= 16'hFFE0), "R7", "vec_hit", {15'b0, vhit}, {15'b0, a >= 16'hFFE0});
    chk(iosel == io, "R8", "io_sel", {15'b0, iosel}, {15'b0, io});
    exp_err = mis;
    if (r) begin
      if (!ok) exp_rdata = '0;
      else if (b) exp_rdata = {8'h00, model[i]};
      else exp_rdata = {model[i | 1], model[i & ~1]};
    end
    if (w && ok) begin
      if (b) model[i] = d[7:0];
      else begin
        model[i & ~1] = d[7:0];
        model[i | 1]  = d[15:8];
      end
    end
    @(negedge clk);
    chk(rdata === exp_rdata, req, "rdata", rdata, exp_rdata);
    chk(aerr === exp_err, mis ? "R6" : req, "align_err", {15'b0, aerr}, {15'b0, exp_err});
  endtask

  function automatic string req_of(logic [15:0] a, bit b, bit r, bit w);
    if ((r | w) && !b && a[0]) return "R6";
    if ((r | w) && a < IO_LIMIT) return "R8";
    if (b) return "R4";
    return "R2";
  endfunction

  initial begin
    #(CLK_PER * WATCHDOG);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata === 16'h0, "R5", "reset rdata", rdata, 16'h0);
    chk(aerr === 1'b0, "R5", "reset align_err", {15'b0, aerr}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill whole array through the alias window above IO_LIMIT (R1)
    for (int k = 0; k < MEM_BYTES; k += 2)
      op(16'(MEM_BYTES + k), 16'(k * 16'h0101 + 16'h1234), 1'b0, 1'b0, 1'b1, "R1");

    // little-endian word write/read (R2)
    op(16'h0A10, 16'hBEEF, 0, 0, 1, "R2");
    op(16'h0A10, 16'h0000, 0, 1, 0, "R2");
    op(16'h0A10, 16'h0000, 1, 1, 0, "R4");
    op(16'h0A11, 16'h0000, 1, 1, 0, "R4");
    // byte write at odd, then even address (R3)
    op(16'h0A11, 16'h5A77, 1, 0, 1, "R3");
    op(16'h0A10, 16'h0000, 0, 1, 0, "R3");
    op(16'h0A10, 16'hC3C3, 1, 0, 1, "R3");
    op(16'h0A10, 16'h0000, 0, 1, 0, "R3");
    // idle holds rdata (R5)
    op(16'h0A20, 16'hFFFF, 0, 0, 0, "R5");
    op(16'h0A20, 16'hFFFF, 0, 0, 0, "R5");
    // odd word write refused, odd word read zero (R6)
    op(16'h0A21, 16'h9999, 0, 0, 1, "R6");
    op(16'h0A20, 16'h0000, 0, 1, 0, "R6");
    op(16'h0A22, 16'h0000, 0, 1, 0, "R6");
    op(16'h0A23, 16'h0000, 0, 1, 0, "R6");
    op(16'h0A22, 16'h0000, 0, 0, 0, "R6");
    // peripheral window: no array write, read zero (R8)
    op(16'h0100, 16'hDEAD, 0, 0, 1, "R8");
    op(16'h0100, 16'h0000, 0, 1, 0, "R8");
    op(16'h0900, 16'h0000, 0, 1, 0, "R8");
    op(16'h01FF, 16'h00AA, 1, 0, 1, "R8");
    op(16'h09FF, 16'h0000, 1, 1, 0, "R8");
    // vector region edges (R7)
    op(16'hFFDF, 16'h0000, 1, 1, 0, "R7");
    op(16'hFFE0, 16'h1111, 0, 0, 1, "R7");
    op(16'hFFFF, 16'h0000, 1, 1, 0, "R7");
    // aliasing (R1)
    op(16'h0FE0, 16'h0000, 0, 1, 0, "R1");
    // read and write together: old data returned (R9)
    op(16'h0B00, 16'h7E57, 0, 1, 1, "R9");
    op(16'h0B00, 16'h0000, 0, 1, 0, "R9");
    op(16'h0B01, 16'h00F0, 1, 1, 1, "R9");
    op(16'h0B00, 16'h0000, 0, 1, 0, "R9");

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      bit b, r, w;
      a = 16'($urandom);
      if (n % 3 != 0) a = 16'(IO_LIMIT) + 16'($urandom_range(0, 2 * MEM_BYTES - 1));
      b = 1'($urandom); r = 1'($urandom); w = 1'($urandom);
      op(a, 16'($urandom), b, r, w, req_of(a, b, r, w));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule